// File: doc/BRIEF.md
# Adaptive-Gate PPS Frequency Counter

This block measures the frequency of a disciplined oscillator against a GPS one-pulse-per-second reference. A slow clock derived from the oscillator (2.5 MHz in the target system) is counted over a gate built from a whole number of PPS seconds. When the gate closes, the block reports the signed difference between the counted cycles and the ideal count, `REF_HZ * 2^exp`. Both inputs are treated as asynchronous. Each passes through a two-flop synchronizer and a rising-edge detector before use.

The gate length is always a power of two seconds, and it adapts after every result. A large absolute error halves the gate, so the loop reacts quickly to drift. A small absolute error doubles it, so a stable oscillator is averaged for longer. The exponent is clamped between `EXP_MIN` and `EXP_MAX`; the defaults give 128 to 2048 seconds. Gates are chained: the PPS edge that closes one gate opens the next one, with the updated length.

After the synthesizer is reprogrammed, its phase is lost. The restart input handles this case. It discards the gate in progress, and the next PPS edge starts a fresh gate. A result is only ever reported for a complete gate.

Top module: `adaptive_gate_counter`

## Requirements
- R1: After reset `valid_o` is 0, `err_o` is 0, `gate_exp_o` equals `EXP_INIT` and `gate_secs_o` equals `2^EXP_INIT`.
- R2: The first `pps_i` rising edge after reset or restart opens a gate and produces no result. The result follows the `2^gate_exp_o`-th PPS rising edge after that.
- R3: `err_o` is the two's-complement value of (tick rising edges counted inside the gate) minus `REF_HZ * 2^exp`, where `exp` is the gate's exponent.
- R4: `valid_o` is a one-cycle pulse. With `pps_i` first sampled high at clock edge k, it is high in the cycle that follows edge k+2, and low before and after that cycle.
- R5: If |err| > `thr_hi_i`, the exponent shown with the result is the previous exponent minus 1, held at `EXP_MIN`.
- R6: If |err| <= `thr_lo_i` and R5 does not apply, the exponent is the previous one plus 1, held at `EXP_MAX`.
- R7: If neither R5 nor R6 applies, the exponent is unchanged. `gate_exp_o` changes only in a `valid_o` cycle, and `gate_secs_o` always equals `2^gate_exp_o`.
- R8: A one-cycle `restart_i` pulse discards the count and the gate in progress. The following PPS edge gives no result and opens a new gate. The next error covers only ticks counted after that edge.
- R9: Gates run back to back. The PPS edge that closes a gate opens the next gate with the updated exponent, and no further arming edge is needed.
- R10: Each rising edge of `tick_i` is counted once, however many system-clock cycles the tick stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Asynchronous divided oscillator clock to be counted |
| pps_i | input | 1 | Asynchronous one-pulse-per-second reference |
| restart_i | input | 1 | Synchronous pulse: drop the current gate and re-arm |
| thr_hi_i | input | THR_W | Error magnitude above which the gate shrinks |
| thr_lo_i | input | THR_W | Error magnitude at or below which the gate grows |
| valid_o | output | 1 | One-cycle result strobe |
| err_o | output | CNT_W+1 | Signed count error of the completed gate |
| gate_exp_o | output | EXP_W | Current gate exponent (log2 of seconds) |
| gate_secs_o | output | EXP_MAX+1 | Current gate length in seconds |

## Verification
A PPS edge driven at a falling clock edge reaches the control logic two rising edges later. The result registers take it on the third rising edge. The bench therefore samples `valid_o` at the second falling edge (expecting 0), at the third (expecting 1 together with `err_o`, `gate_exp_o` and `gate_secs_o`), and at the fourth (expecting 0 again). Ticks go through the same three-stage path. The bench leaves several idle cycles between the last tick of a second and the next PPS edge, so every tick falls unambiguously inside its gate. The expected error and the next exponent are computed arithmetically from the number of ticks the bench drove and from the threshold rule.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic {
    ST_ARMED = 1'b0,
    ST_GATE  = 1'b1
  } gate_state_e;
endpackage

// File: rtl/agc_edge_sync.sv
module agc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its delayed copy
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/agc_tick_counter.sv
module agc_tick_counter #(
  parameter int CNT_W = 34
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (inc_i && !(&cnt_q))  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/agc_gate_ctrl.sv
module agc_gate_ctrl
  import agc_pkg::*;
#(
  parameter int REF_HZ   = 2_500_000,
  parameter int CNT_W    = 34,
  parameter int THR_W    = 16,
  parameter int EXP_MIN  = 7,
  parameter int EXP_MAX  = 11,
  parameter int EXP_INIT = 7,
  localparam int EXP_W   = $clog2(EXP_MAX + 1),
  localparam int SEC_W   = EXP_MAX + 1,
  localparam int ERR_W   = CNT_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pps_rise_i,
  input  logic                    restart_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [THR_W-1:0]        thr_hi_i,
  input  logic [THR_W-1:0]        thr_lo_i,
  output logic                    cnt_clr_o,
  output logic                    valid_o,
  output logic signed [ERR_W-1:0] err_o,
  output logic [EXP_W-1:0]        gate_exp_o,
  output logic [SEC_W-1:0]        gate_secs_o
);
  gate_state_e state_q;
  logic [SEC_W-1:0] sec_q;
  logic [EXP_W-1:0] exp_q, exp_nxt;
  logic [SEC_W-1:0] gate_secs;
  logic [CNT_W-1:0] ideal;
  logic [ERR_W-1:0] diff, mag;
  logic             last_sec, too_big, quiet, close_gate;
  logic             valid_q;
  logic [ERR_W-1:0] err_q;

  assign gate_secs  = SEC_W'(1) << exp_q;
  assign last_sec   = (sec_q == gate_secs - 1'b1);
  assign ideal      = CNT_W'(REF_HZ) << exp_q;
  assign diff       = {1'b0, cnt_i} - {1'b0, ideal};
  assign mag        = diff[ERR_W-1] ? (ERR_W'(0) - diff) : diff;
  assign too_big    = mag >  ERR_W'(thr_hi_i);
  assign quiet      = mag <= ERR_W'(thr_lo_i);
  assign close_gate = pps_rise_i && (state_q == ST_GATE) && last_sec;

  always_comb begin
    exp_nxt = exp_q;
    if (too_big) begin
      if (exp_q > EXP_W'(EXP_MIN)) exp_nxt = exp_q - 1'b1;
    end else if (quiet) begin
      if (exp_q < EXP_W'(EXP_MAX)) exp_nxt = exp_q + 1'b1;
    end
  end

  // counter restarts at every open/close edge and on restart
  assign cnt_clr_o = restart_i | (pps_rise_i & ((state_q == ST_ARMED) | last_sec));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ARMED;
      sec_q   <= '0;
      exp_q   <= EXP_W'(EXP_INIT);
      valid_q <= 1'b0;
      err_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      if (restart_i) begin
        state_q <= ST_ARMED;
        sec_q   <= '0;
      end else if (pps_rise_i) begin
        if (state_q == ST_ARMED) begin
          state_q <= ST_GATE;
          sec_q   <= '0;
        end else if (close_gate) begin
          valid_q <= 1'b1;
          err_q   <= diff;
          exp_q   <= exp_nxt;
          sec_q   <= '0;
        end else begin
          sec_q   <= sec_q + 1'b1;
        end
      end
    end
  end

  assign valid_o     = valid_q;
  assign err_o       = $signed(err_q);
  assign gate_exp_o  = exp_q;
  assign gate_secs_o = gate_secs;
endmodule

// File: rtl/adaptive_gate_counter.sv
module adaptive_gate_counter #(
  parameter int REF_HZ   = 2_500_000,
  parameter int CNT_W    = 34,
  parameter int THR_W    = 16,
  parameter int EXP_MIN  = 7,
  parameter int EXP_MAX  = 11,
  parameter int EXP_INIT = 7,
  parameter int SYNC_STAGES = 2,
  localparam int EXP_W   = $clog2(EXP_MAX + 1),
  localparam int SEC_W   = EXP_MAX + 1,
  localparam int ERR_W   = CNT_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    pps_i,
  input  logic                    restart_i,
  input  logic [THR_W-1:0]        thr_hi_i,
  input  logic [THR_W-1:0]        thr_lo_i,
  output logic                    valid_o,
  output logic signed [ERR_W-1:0] err_o,
  output logic [EXP_W-1:0]        gate_exp_o,
  output logic [SEC_W-1:0]        gate_secs_o
);
  logic [1:0] async_in, rise;
  logic [CNT_W-1:0] cnt;
  logic cnt_clr;

  assign async_in = {pps_i, tick_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    agc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (async_in[g]),
      .rise_o(rise[g])
    );
  end

  agc_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (rise[0]),
    .cnt_o (cnt)
  );

  agc_gate_ctrl #(
    .REF_HZ  (REF_HZ),
    .CNT_W   (CNT_W),
    .THR_W   (THR_W),
    .EXP_MIN (EXP_MIN),
    .EXP_MAX (EXP_MAX),
    .EXP_INIT(EXP_INIT)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pps_rise_i (rise[1]),
    .restart_i  (restart_i),
    .cnt_i      (cnt),
    .thr_hi_i   (thr_hi_i),
    .thr_lo_i   (thr_lo_i),
    .cnt_clr_o  (cnt_clr),
    .valid_o    (valid_o),
    .err_o      (err_o),
    .gate_exp_o (gate_exp_o),
    .gate_secs_o(gate_secs_o)
  );
endmodule

// File: rtl/agc_checker.sv
module agc_checker #(
  parameter int CNT_W   = 34,
  parameter int THR_W   = 16,
  parameter int EXP_MIN = 7,
  parameter int EXP_MAX = 11,
  localparam int EXP_W  = $clog2(EXP_MAX + 1),
  localparam int SEC_W  = EXP_MAX + 1,
  localparam int ERR_W  = CNT_W + 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    tick_i,
  input logic                    pps_i,
  input logic                    restart_i,
  input logic [THR_W-1:0]        thr_hi_i,
  input logic [THR_W-1:0]        thr_lo_i,
  input logic                    valid_o,
  input logic signed [ERR_W-1:0] err_o,
  input logic [EXP_W-1:0]        gate_exp_o,
  input logic [SEC_W-1:0]        gate_secs_o
);
  logic [ERR_W-1:0] mag_c;
  logic big_c, quiet_c;
  assign mag_c   = err_o[ERR_W-1] ? (ERR_W'(0) - err_o) : err_o;
  assign big_c   = mag_c >  ERR_W'(thr_hi_i);
  assign quiet_c = mag_c <= ERR_W'(thr_lo_i);

  // R4
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R5
  shrink_on_large_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && big_c) |-> gate_exp_o == (($past(gate_exp_o) > EXP_W'(EXP_MIN)) ?
                                          $past(gate_exp_o) - 1'b1 : $past(gate_exp_o)));

  // R6
  grow_on_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !big_c && quiet_c) |-> gate_exp_o == (($past(gate_exp_o) < EXP_W'(EXP_MAX)) ?
                                          $past(gate_exp_o) + 1'b1 : $past(gate_exp_o)));

  // R7
  hold_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !big_c && !quiet_c) |-> $stable(gate_exp_o));

  // R7
  exp_moves_with_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gate_exp_o) |-> valid_o);

  // R1
  exp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_exp_o >= EXP_W'(EXP_MIN) && gate_exp_o <= EXP_W'(EXP_MAX));

  // R8
  restart_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !valid_o);

  // R7
  secs_track_exp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gate_secs_o) == 1);
endmodule

bind adaptive_gate_counter agc_checker #(
  .CNT_W  (CNT_W),
  .THR_W  (THR_W),
  .EXP_MIN(EXP_MIN),
  .EXP_MAX(EXP_MAX)
) u_agc_checker (.*);

// File: tb/adaptive_gate_counter_bench.sv
module adaptive_gate_counter_bench;
  localparam int REF_HZ = 8;
  localparam int CNT_W  = 8;
  localparam int THR_W  = 8;
  localparam int EMIN   = 0;
  localparam int EMAX   = 3;
  localparam int EINIT  = 1;
  localparam int EXP_W  = $clog2(EMAX + 1);
  localparam int ERR_W  = CNT_W + 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, pps_i = 1'b0, restart_i = 1'b0;
  logic [THR_W-1:0] thr_hi_i = 8'd2, thr_lo_i = 8'd0;
  logic valid_o;
  logic signed [ERR_W-1:0] err_o;
  logic [EXP_W-1:0] gate_exp_o;
  logic [EMAX:0] gate_secs_o;

  always #10 clk_i = ~clk_i;

  adaptive_gate_counter #(
    .REF_HZ(REF_HZ), .CNT_W(CNT_W), .THR_W(THR_W),
    .EXP_MIN(EMIN), .EXP_MAX(EMAX), .EXP_INIT(EINIT)
  ) u_adaptive_gate_counter (.*);

  int n_chk = 0, n_bad = 0;
  int m_exp = EINIT;
  int t_hi = 2, t_lo = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic send_ticks(int n, int hi_len);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      repeat (hi_len) @(negedge clk_i);
      tick_i = 1'b0;
      repeat (2) @(negedge clk_i);
    end
    repeat (4) @(negedge clk_i);
  endtask

  // R4 timing: driven at n0, result due at n3
  task automatic pps_edge(bit want, int e_err, string tag);
    @(negedge clk_i); pps_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R4 early", int'(valid_o), 0);
    @(negedge clk_i);
    chk(valid_o == want, {"R4/R2 strobe ", tag}, int'(valid_o), int'(want));
    if (want) begin
      chk(int'(err_o) == e_err, {"R3 error ", tag}, int'(err_o), e_err);
      chk(int'(gate_exp_o) == m_exp, {"R5/R6/R7 exponent ", tag}, int'(gate_exp_o), m_exp);
      chk(int'(gate_secs_o) == (1 << m_exp), "R7 seconds", int'(gate_secs_o), 1 << m_exp);
    end
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R4 single", int'(valid_o), 0);
    pps_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  function automatic int next_exp(int e, int d);
    int mag = (d < 0) ? -d : d;
    if (mag > t_hi) return (e > EMIN) ? e - 1 : e;
    if (mag <= t_lo) return (e < EMAX) ? e + 1 : e;
    return e;
  endfunction

  // R9: assumes gate already open
  task automatic run_gate(int delta, int hi_len, string tag);
    int secs = 1 << m_exp;
    for (int s = 0; s < secs; s++) begin
      if (s == secs - 1) begin
        send_ticks(REF_HZ + delta, hi_len);
        m_exp = next_exp(m_exp, delta);
        pps_edge(1'b1, delta, tag);
      end else begin
        send_ticks(REF_HZ, hi_len);
        pps_edge(1'b0, 0, {"R9 mid ", tag});
      end
    end
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 150000) begin
      @(posedge clk_i);
      wd++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", wd);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(valid_o == 1'b0, "R1 valid", int'(valid_o), 0);
    chk(int'(err_o) == 0, "R1 err", int'(err_o), 0);
    chk(int'(gate_exp_o) == EINIT, "R1 exp", int'(gate_exp_o), EINIT);
    chk(int'(gate_secs_o) == (1 << EINIT), "R1 secs", int'(gate_secs_o), 1 << EINIT);

    // R2: ticks before the arming edge are not counted
    send_ticks(5, 2);
    pps_edge(1'b0, 0, "R2 arm");

    // R5 R6 R7 walk: exp 1,2,3,3,2,1,0,0,0,0,1
    run_gate(0,  2, "R6 grow");
    run_gate(0,  2, "R6 grow");
    run_gate(0,  2, "R6 clamp max");
    run_gate(3,  2, "R5 shrink");
    run_gate(-5, 2, "R5 shrink neg");
    run_gate(4,  2, "R5 shrink");
    run_gate(-3, 2, "R5 clamp min");
    run_gate(1,  2, "R7 hold");
    run_gate(-2, 2, "R7 hold");
    run_gate(0,  2, "R6 grow");

    // R8: restart discards a partial gate (exp 1 => 2 s gate)
    send_ticks(5, 2);
    pps_edge(1'b0, 0, "R8 mid");
    send_ticks(4, 2);
    @(negedge clk_i); restart_i = 1'b1;
    @(negedge clk_i); restart_i = 1'b0;
    pps_edge(1'b0, 0, "R8 no result after restart");
    run_gate(-1, 2, "R8 fresh gate");

    // R10: long-held ticks counted once
    run_gate(2, 5, "R10 long ticks");

    // second threshold set, sweep of errors
    thr_hi_i = 8'd5; thr_lo_i = 8'd2; t_hi = 5; t_lo = 2;
    for (int d = -7; d <= 7; d += 2) run_gate(d, 2, "sweep");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule